// File: doc/BRIEF.md
# Piecewise-Linear Gamma Corrector

This block applies a tone curve to a stream of 10-bit luminance samples and produces 8-bit output samples. The curve is not held as a full lookup table. It is built from seven straight segments. Each segment has a start point, an output value at that start point, and a slope. A 2-bit select input picks one of four curve families: a fixed 0.45 power curve, a register-programmable set that comes up as a 0.6 power curve, a fixed straight line, and a fixed S-shaped contrast curve.

An optional sharpening (aperture) term can be added to every sample. A control register bit sets where the term goes: before the curve, on the 10-bit input, or after the curve, on the 8-bit result. The aperture term is computed outside this block.

The block is a fixed three-stage pipeline with no stalls. The first stage does the pre-curve addition. The second stage finds the segment. The third stage does the multiply-add and the final clip. A valid flag travels with each sample.

Top module: `pwl_gamma_corrector`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three clock edges earlier. Samples may arrive in any pattern of gaps.
- R2: The segment index of a curve input equals the number of its six breakpoints that are less than or equal to that input. Breakpoints are assumed ascending. Segment 0 starts at 0, and segment k>0 starts at breakpoint k-1.
- R3: A segment's result is base + floor((input − segment start) × slope / 64). The slope is unsigned, with 6 fraction bits.
- R4: Select 00 uses knots x = 0,16,48,112,240,432,688,1024 and y = 0,39,64,94,133,173,213,255. Segment k has base y_k and slope floor(64·(y_{k+1}−y_k)/(x_{k+1}−x_k)). Breakpoints are x_1..x_6.
- R5: Select 10 uses knots x = 0,128,256,384,512,640,768,1024 and y = 0,32,64,96,128,160,192,256, built the same way as in R4. The result is floor(input/4).
- R6: Select 11 uses knots x = 0,160,320,448,576,704,864,1024 and y = 0,12,48,100,156,208,243,255, built the same way as in R4.
- R7: Select 01 uses the programmable set. Writes are word writes at the following addresses:
  - 0..5: breakpoints 0..5 (10 bits).
  - 8..14: bases of segments 0..6 (low 8 bits).
  - 16..22: slopes of segments 0..6 (10 bits).
  - 24: control; bit 0 is 1 for after-curve aperture.
  
  After reset, this set holds the knots x = 0,16,48,112,240,432,688,1024 and y = 0,21,41,68,107,152,201,255, built as in R4, and the control bit is 0.
- R8: Writes to the programmable set have no effect on selects 00, 10 and 11.
- R9: When `ap_en` is 0, `ap_term` has no effect on the output.
- R10: When `ap_en` is 1 and the control bit is 0, the curve input is in_pix + ap_term, clamped to 0..1023.
- R11: When `ap_en` is 1 and the control bit is 1, ap_term is added to the curve result.
- R12: The final output is clipped to 0..255. This covers programmed segments whose result goes past 255.
- R13: While reset is held, and on the edges that follow until the first sample can arrive, `out_valid` is 0. During reset `out_pix` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_pix | input | IN_W | Luminance sample in |
| curve_sel | input | 2 | Curve family select |
| ap_en | input | 1 | Aperture term enable |
| ap_term | input | AP_W | Signed aperture term |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| out_valid | output | 1 | Output sample qualifier |
| out_pix | output | OUT_W | Corrected sample out |

## Verification
The pre-curve aperture addition and the breakpoint search act on the same sample in consecutive stages. An aperture term can push a sample across a breakpoint, or past either end of the input range, in the same cycle that the segment is chosen. The bench provokes this by sweeping every input code with both large and small aperture terms of each sign. Each output is judged against an arithmetic model that clamps first and then applies the segment formula. The after-curve addition and the final clip meet in the same way: extreme terms on both ends of the curve must saturate exactly at 0 and at 255.

// File: rtl/pwl_gamma_pkg.sv
// Shared constants for the piecewise-linear gamma corrector: segment counts,
// knot tables of the four curve families, register map, curve select codes.
// Assumes the default widths (10-bit in, 8-bit out, 6 slope fraction bits).
package pwl_gamma_pkg;
    localparam int NSEG  = 7;
    localparam int NKNOT = NSEG + 1;
    localparam int NBP   = NSEG - 1;

    typedef int knot_t [NKNOT];

    localparam knot_t G45_X = '{0, 16, 48, 112, 240, 432, 688, 1024};
    localparam knot_t G45_Y = '{0, 39, 64, 94, 133, 173, 213, 255};
    localparam knot_t G60_X = '{0, 16, 48, 112, 240, 432, 688, 1024};
    localparam knot_t G60_Y = '{0, 21, 41, 68, 107, 152, 201, 255};
    localparam knot_t LIN_X = '{0, 128, 256, 384, 512, 640, 768, 1024};
    localparam knot_t LIN_Y = '{0, 32, 64, 96, 128, 160, 192, 256};
    localparam knot_t SCV_X = '{0, 160, 320, 448, 576, 704, 864, 1024};
    localparam knot_t SCV_Y = '{0, 12, 48, 100, 156, 208, 243, 255};

    typedef enum logic [1:0] {
        CURVE_G45  = 2'b00,
        CURVE_PROG = 2'b01,
        CURVE_LIN  = 2'b10,
        CURVE_SCV  = 2'b11
    } curve_e;

    localparam int REG_BP    = 0;
    localparam int REG_BASE  = 8;
    localparam int REG_SLOPE = 16;
    localparam int REG_CTRL  = 24;

    // Knot abscissa i of curve family c.
    function automatic int knot_x(input int c, input int i);
        case (c)
            0:       return G45_X[i];
            1:       return G60_X[i];
            2:       return LIN_X[i];
            default: return SCV_X[i];
        endcase
    endfunction

    // Knot ordinate i of curve family c.
    function automatic int knot_y(input int c, input int i);
        case (c)
            0:       return G45_Y[i];
            1:       return G60_Y[i];
            2:       return LIN_Y[i];
            default: return SCV_Y[i];
        endcase
    endfunction

    // Fixed-point slope of segment s of family c with frac fraction bits.
    function automatic int knot_slope(input int c, input int s, input int frac);
        return ((knot_y(c, s + 1) - knot_y(c, s)) * (1 << frac)) /
               (knot_x(c, s + 1) - knot_x(c, s));
    endfunction
endpackage

// File: rtl/pwl_gamma_regs.sv
// Programmable curve set and aperture position bit.
// Reset loads the 0.6 power curve; writes land one edge after the strobe.
// Assumes DATA_W covers both IN_W and SLOPE_W.
module pwl_gamma_regs
    import pwl_gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 8,
    parameter int SLOPE_W = 10,
    parameter int FRAC    = 6,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_we,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [NBP-1:0][IN_W-1:0]        prog_bp,
    output logic [NSEG-1:0][OUT_W-1:0]      prog_base,
    output logic [NSEG-1:0][SLOPE_W-1:0]    prog_slope,
    output logic                            ap_post
);
    // Breakpoint registers: reset to the 0.6 knots, then word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NBP; j++)
                prog_bp[j] <= IN_W'(knot_x(1, j + 1));
        end else if (reg_we) begin
            for (int j = 0; j < NBP; j++)
                if (reg_addr == ADDR_W'(REG_BP + j))
                    prog_bp[j] <= reg_wdata[IN_W-1:0];
        end
    end

    // Base and slope registers per segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSEG; s++) begin
                prog_base[s]  <= OUT_W'(knot_y(1, s));
                prog_slope[s] <= SLOPE_W'(knot_slope(1, s, FRAC));
            end
        end else if (reg_we) begin
            for (int s = 0; s < NSEG; s++) begin
                if (reg_addr == ADDR_W'(REG_BASE + s))
                    prog_base[s] <= reg_wdata[OUT_W-1:0];
                if (reg_addr == ADDR_W'(REG_SLOPE + s))
                    prog_slope[s] <= reg_wdata[SLOPE_W-1:0];
            end
        end
    end

    // Aperture position bit: 0 adds before the curve, 1 after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ap_post <= 1'b0;
        else if (reg_we && reg_addr == ADDR_W'(REG_CTRL))
            ap_post <= reg_wdata[0];
    end
endmodule

// File: rtl/pwl_gamma_curves.sv
// Curve parameter multiplexer: presents the breakpoints, bases and slopes of
// the selected family. Fixed families are elaboration-time constants.
module pwl_gamma_curves
    import pwl_gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 8,
    parameter int SLOPE_W = 10,
    parameter int FRAC    = 6
) (
    input  curve_e                          sel,
    input  logic [NBP-1:0][IN_W-1:0]        prog_bp,
    input  logic [NSEG-1:0][OUT_W-1:0]      prog_base,
    input  logic [NSEG-1:0][SLOPE_W-1:0]    prog_slope,
    output logic [NBP-1:0][IN_W-1:0]        cur_bp,
    output logic [NSEG-1:0][OUT_W-1:0]      cur_base,
    output logic [NSEG-1:0][SLOPE_W-1:0]    cur_slope
);
    typedef logic [NBP-1:0][IN_W-1:0]      bp_vec_t;
    typedef logic [NSEG-1:0][OUT_W-1:0]    base_vec_t;
    typedef logic [NSEG-1:0][SLOPE_W-1:0]  slope_vec_t;

    function automatic bp_vec_t mk_bp(input int c);
        bp_vec_t v;
        for (int j = 0; j < NBP; j++) v[j] = IN_W'(knot_x(c, j + 1));
        return v;
    endfunction

    function automatic base_vec_t mk_base(input int c);
        base_vec_t v;
        for (int s = 0; s < NSEG; s++) v[s] = OUT_W'(knot_y(c, s));
        return v;
    endfunction

    function automatic slope_vec_t mk_slope(input int c);
        slope_vec_t v;
        for (int s = 0; s < NSEG; s++) v[s] = SLOPE_W'(knot_slope(c, s, FRAC));
        return v;
    endfunction

    localparam bp_vec_t    G45_BP = mk_bp(0);
    localparam base_vec_t  G45_BS = mk_base(0);
    localparam slope_vec_t G45_SL = mk_slope(0);
    localparam bp_vec_t    LIN_BP = mk_bp(2);
    localparam base_vec_t  LIN_BS = mk_base(2);
    localparam slope_vec_t LIN_SL = mk_slope(2);
    localparam bp_vec_t    SCV_BP = mk_bp(3);
    localparam base_vec_t  SCV_BS = mk_base(3);
    localparam slope_vec_t SCV_SL = mk_slope(3);

    // Pick the active parameter set.
    always_comb begin
        case (sel)
            CURVE_G45: begin
                cur_bp = G45_BP; cur_base = G45_BS; cur_slope = G45_SL;
            end
            CURVE_PROG: begin
                cur_bp = prog_bp; cur_base = prog_base; cur_slope = prog_slope;
            end
            CURVE_LIN: begin
                cur_bp = LIN_BP; cur_base = LIN_BS; cur_slope = LIN_SL;
            end
            default: begin
                cur_bp = SCV_BP; cur_base = SCV_BS; cur_slope = SCV_SL;
            end
        endcase
    end
endmodule

// File: rtl/pwl_gamma_segsel.sv
// Segment finder: the index is the count of breakpoints at or below the
// input, so all compares run in parallel. Assumes ascending breakpoints.
module pwl_gamma_segsel
    import pwl_gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 8,
    parameter int SLOPE_W = 10
) (
    input  logic [IN_W-1:0]                 x,
    input  logic [NBP-1:0][IN_W-1:0]        cur_bp,
    input  logic [NSEG-1:0][OUT_W-1:0]      cur_base,
    input  logic [NSEG-1:0][SLOPE_W-1:0]    cur_slope,
    output logic [OUT_W-1:0]                seg_base,
    output logic [SLOPE_W-1:0]              seg_slope,
    output logic [IN_W-1:0]                 seg_off
);
    localparam int IDX_W = $clog2(NSEG);

    logic [NBP-1:0]   at_or_above;
    logic [IDX_W-1:0] idx;
    logic [IN_W-1:0]  seg_start;

    // One comparator per breakpoint.
    for (genvar j = 0; j < NBP; j++) begin : g_cmp
        assign at_or_above[j] = (x >= cur_bp[j]);
    end

    // Count passed breakpoints, then fetch the segment's parameters.
    always_comb begin
        idx = '0;
        for (int j = 0; j < NBP; j++)
            if (at_or_above[j]) idx = idx + IDX_W'(1);
        seg_start = (idx == '0) ? '0 : cur_bp[idx - IDX_W'(1)];
        seg_base  = cur_base[idx];
        seg_slope = cur_slope[idx];
        seg_off   = x - seg_start;
    end
endmodule

// File: rtl/pwl_gamma_corrector.sv
// Three-stage gamma corrector: stage 1 adds an optional aperture term before
// the curve, stage 2 finds the segment, stage 3 multiplies, adds base and an
// optional after-curve term, then clips. No stalls; valid follows the data.
module pwl_gamma_corrector
    import pwl_gamma_pkg::*;
#(
    parameter int IN_W    = 10,
    parameter int OUT_W   = 8,
    parameter int SLOPE_W = 10,
    parameter int FRAC    = 6,
    parameter int AP_W    = 9,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_pix,
    input  logic [1:0]              curve_sel,
    input  logic                    ap_en,
    input  logic signed [AP_W-1:0]  ap_term,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_pix
);
    localparam int MAX_IN  = (1 << IN_W) - 1;
    localparam int MAX_OUT = (1 << OUT_W) - 1;
    localparam int PRE_W   = IN_W + 2;
    localparam int PROD_W  = IN_W + SLOPE_W;
    localparam int SUM_W   = PROD_W + 2;

    logic [NBP-1:0][IN_W-1:0]      prog_bp, cur_bp;
    logic [NSEG-1:0][OUT_W-1:0]    prog_base, cur_base;
    logic [NSEG-1:0][SLOPE_W-1:0]  prog_slope, cur_slope;
    logic                          ap_post;

    pwl_gamma_regs #(
        .IN_W(IN_W), .OUT_W(OUT_W), .SLOPE_W(SLOPE_W), .FRAC(FRAC),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .prog_bp(prog_bp), .prog_base(prog_base),
        .prog_slope(prog_slope), .ap_post(ap_post)
    );

    // ---------------- stage 1: pre-curve aperture ----------------
    logic signed [PRE_W-1:0] pre_sum;
    logic [IN_W-1:0]         pre_x;
    logic                    use_pre, use_post;
    logic                    s1_valid;
    logic [IN_W-1:0]         s1_x;
    curve_e                  s1_sel;
    logic signed [AP_W-1:0]  s1_ap;

    // Add the term to the raw sample and clamp to the input range.
    always_comb begin
        use_pre  = ap_en & ~ap_post;
        use_post = ap_en & ap_post;
        pre_sum  = $signed({2'b00, in_pix}) + PRE_W'(ap_term);
        if (pre_sum < 0)
            pre_x = '0;
        else if (pre_sum > MAX_IN)
            pre_x = IN_W'(MAX_IN);
        else
            pre_x = pre_sum[IN_W-1:0];
    end

    // Stage 1 register: curve input, select, deferred term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
            s1_sel   <= CURVE_G45;
            s1_ap    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_x     <= use_pre ? pre_x : in_pix;
            s1_sel   <= curve_e'(curve_sel);
            s1_ap    <= use_post ? ap_term : '0;
        end
    end

    // ---------------- stage 2: segment search ----------------
    logic [OUT_W-1:0]        seg_base;
    logic [SLOPE_W-1:0]      seg_slope;
    logic [IN_W-1:0]         seg_off;
    logic                    s2_valid;
    logic [OUT_W-1:0]        s2_base;
    logic [SLOPE_W-1:0]      s2_slope;
    logic [IN_W-1:0]         s2_off;
    logic signed [AP_W-1:0]  s2_ap;

    pwl_gamma_curves #(
        .IN_W(IN_W), .OUT_W(OUT_W), .SLOPE_W(SLOPE_W), .FRAC(FRAC)
    ) u_curves (
        .sel(s1_sel), .prog_bp(prog_bp), .prog_base(prog_base),
        .prog_slope(prog_slope), .cur_bp(cur_bp), .cur_base(cur_base),
        .cur_slope(cur_slope)
    );

    pwl_gamma_segsel #(
        .IN_W(IN_W), .OUT_W(OUT_W), .SLOPE_W(SLOPE_W)
    ) u_segsel (
        .x(s1_x), .cur_bp(cur_bp), .cur_base(cur_base), .cur_slope(cur_slope),
        .seg_base(seg_base), .seg_slope(seg_slope), .seg_off(seg_off)
    );

    // Stage 2 register: chosen segment's base, slope and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_base  <= '0;
            s2_slope <= '0;
            s2_off   <= '0;
            s2_ap    <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_base  <= seg_base;
            s2_slope <= seg_slope;
            s2_off   <= seg_off;
            s2_ap    <= s1_ap;
        end
    end

    // ---------------- stage 3: evaluate and clip ----------------
    logic [PROD_W-1:0]        prod;
    logic signed [SUM_W-1:0]  total;
    logic [OUT_W-1:0]         clipped;

    // Base plus scaled offset plus after-curve term, clipped to output range.
    always_comb begin
        prod  = PROD_W'(s2_off) * PROD_W'(s2_slope);
        total = $signed(SUM_W'(s2_base)) + $signed(SUM_W'(prod >> FRAC))
              + SUM_W'(s2_ap);
        if (total < 0)
            clipped = '0;
        else if (total > MAX_OUT)
            clipped = OUT_W'(MAX_OUT);
        else
            clipped = total[OUT_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_pix   <= clipped;
        end
    end
endmodule

// File: rtl/pwl_gamma_chk.sv
// Checker for the gamma corrector: latency, reset quiet period, and the
// linear curve with the aperture term in each position. Assumes default
// widths, for which the linear family is a right shift by IN_W-OUT_W.
module pwl_gamma_chk #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8,
    parameter int AP_W  = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [IN_W-1:0]        in_pix,
    input logic [1:0]             curve_sel,
    input logic                   ap_en,
    input logic signed [AP_W-1:0] ap_term,
    input logic                   ap_post,
    input logic                   out_valid,
    input logic [OUT_W-1:0]       out_pix
);
    localparam int MAX_IN  = (1 << IN_W) - 1;
    localparam int MAX_OUT = (1 << OUT_W) - 1;
    localparam int SHIFT   = IN_W - OUT_W;

    logic [1:0] since_rst;

    // Edges since reset release, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    function automatic logic [OUT_W-1:0] lin_pre(input logic [IN_W-1:0] x,
                                                 input logic signed [AP_W-1:0] a);
        int s;
        s = int'(x) + int'(a);
        if (s < 0) s = 0;
        if (s > MAX_IN) s = MAX_IN;
        return OUT_W'(s >> SHIFT);
    endfunction

    function automatic logic [OUT_W-1:0] lin_post(input logic [IN_W-1:0] x,
                                                  input logic signed [AP_W-1:0] a);
        int s;
        s = (int'(x) >> SHIFT) + int'(a);
        if (s < 0) s = 0;
        if (s > MAX_OUT) s = MAX_OUT;
        return OUT_W'(s);
    endfunction

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_quiet_after_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !out_valid);

    assert_linear_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3) && $past(curve_sel, 3) == 2'b10
         && !$past(ap_en, 3))
        |-> (out_pix == OUT_W'($past(in_pix, 3) >> SHIFT)));

    assert_linear_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3) && $past(curve_sel, 3) == 2'b10
         && $past(ap_en, 3) && !$past(ap_post, 3))
        |-> (out_pix == lin_pre($past(in_pix, 3), $past(ap_term, 3))));

    assert_linear_post_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3) && $past(curve_sel, 3) == 2'b10
         && $past(ap_en, 3) && $past(ap_post, 3))
        |-> (out_pix == lin_post($past(in_pix, 3), $past(ap_term, 3))));
endmodule

bind pwl_gamma_corrector pwl_gamma_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .AP_W(AP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .curve_sel(curve_sel), .ap_en(ap_en), .ap_term(ap_term),
    .ap_post(ap_post), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/pwl_gamma_corrector_test.sv
// Sweeps every input code through each curve family and aperture mode,
// comparing against an arithmetic model built from the stated knots.
module pwl_gamma_corrector_test;
    localparam int IN_W = 10, OUT_W = 8, AP_W = 9, ADDR_W = 5, DATA_W = 10;
    localparam int NPIX = 1 << IN_W;

    localparam int KX [4][8] = '{
        '{0, 16, 48, 112, 240, 432, 688, 1024},
        '{0, 16, 48, 112, 240, 432, 688, 1024},
        '{0, 128, 256, 384, 512, 640, 768, 1024},
        '{0, 160, 320, 448, 576, 704, 864, 1024}};
    localparam int KY [4][8] = '{
        '{0, 39, 64, 94, 133, 173, 213, 255},
        '{0, 21, 41, 68, 107, 152, 201, 255},
        '{0, 32, 64, 96, 128, 160, 192, 256},
        '{0, 12, 48, 100, 156, 208, 243, 255}};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                   rst_n;
    logic                   in_valid;
    logic [IN_W-1:0]        in_pix;
    logic [1:0]             curve_sel;
    logic                   ap_en;
    logic signed [AP_W-1:0] ap_term;
    logic                   reg_we;
    logic [ADDR_W-1:0]      reg_addr;
    logic [DATA_W-1:0]      reg_wdata;
    logic                   out_valid;
    logic [OUT_W-1:0]       out_pix;

    pwl_gamma_corrector uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .curve_sel(curve_sel), .ap_en(ap_en), .ap_term(ap_term),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .out_valid(out_valid), .out_pix(out_pix));

    int n_checks = 0, n_fail = 0;

    // Model of the programmable set and position bit.
    int m_bp [6];
    int m_base [7];
    int m_slope [7];
    bit m_post;

    // Expected-value pipeline, index 2 is due at the current negedge.
    bit    e_v [3];
    int    e_p [3];
    int    e_x [3];
    string e_t [3];

    function automatic int seg_eval(input int bp[6], input int bs[7],
                                    input int sl[7], input int x);
        int k = 0;
        int st;
        for (int j = 0; j < 6; j++) if (x >= bp[j]) k++;
        st = (k == 0) ? 0 : bp[k-1];
        return bs[k] + ((x - st) * sl[k]) / 64;
    endfunction

    function automatic int expect_pix(input int sel, input int x,
                                      input bit apen, input int ap);
        int bp [6];
        int bs [7];
        int sl [7];
        int xi = x;
        int y;
        if (apen && !m_post) begin
            xi = x + ap;
            if (xi < 0) xi = 0;
            if (xi > NPIX - 1) xi = NPIX - 1;
        end
        if (sel == 1) begin
            bp = m_bp; bs = m_base; sl = m_slope;
        end else begin
            for (int j = 0; j < 6; j++) bp[j] = KX[sel][j+1];
            for (int s = 0; s < 7; s++) begin
                bs[s] = KY[sel][s];
                sl[s] = (KY[sel][s+1] - KY[sel][s]) * 64 / (KX[sel][s+1] - KX[sel][s]);
            end
        end
        y = seg_eval(bp, bs, sl, xi);
        if (apen && m_post) y = y + ap;
        if (y < 0) y = 0;
        if (y > 255) y = 255;
        return y;
    endfunction

    // One cycle: check the output due now, then drive the next sample.
    task automatic step(input bit v, input int x, input int sel, input bit apen,
                        input int ap, input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== e_v[2]) begin
            n_fail++;
            $display("FAIL %s: out_valid=%0b expected %0b", e_t[2], out_valid, e_v[2]);
        end else if (e_v[2] && out_pix !== OUT_W'(e_p[2])) begin
            n_fail++;
            $display("FAIL %s: in=%0d out_pix=%0d expected %0d",
                     e_t[2], e_x[2], out_pix, e_p[2]);
        end
        for (int i = 2; i > 0; i--) begin
            e_v[i] = e_v[i-1]; e_p[i] = e_p[i-1]; e_x[i] = e_x[i-1]; e_t[i] = e_t[i-1];
        end
        e_v[0] = v;
        e_x[0] = x;
        e_t[0] = (tag == "") ? "R1" : tag;
        e_p[0] = v ? expect_pix(sel, x, apen, ap) : 0;
        in_valid  = v;
        in_pix    = IN_W'(x);
        curve_sel = 2'(sel);
        ap_en     = apen;
        ap_term   = AP_W'(ap);
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R1");
    endtask

    // Register write, carried on an idle pixel cycle.
    task automatic wr(input int addr, input int data);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(addr);
        reg_wdata = DATA_W'(data);
        if (addr < 6) m_bp[addr] = data;
        else if (addr >= 8 && addr < 15) m_base[addr-8] = data & 255;
        else if (addr >= 16 && addr < 23) m_slope[addr-16] = data;
        else if (addr == 24) m_post = data[0];
        step(0, 0, 0, 0, 0, "R7");
        reg_we = 1'b0;
    endtask

    task automatic sweep(input int sel, input bit apen, input int ap,
                         input bit gaps, input string tag);
        for (int x = 0; x < NPIX; x++) begin
            if (gaps && (x % 3 == 0)) step(0, 0, sel, apen, ap, "R1");
            step(1, x, sel, apen, ap, tag);
        end
        flush();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < 6; j++) m_bp[j] = KX[1][j+1];
        for (int s = 0; s < 7; s++) begin
            m_base[s]  = KY[1][s];
            m_slope[s] = (KY[1][s+1] - KY[1][s]) * 64 / (KX[1][s+1] - KX[1][s]);
        end
        m_post = 0;
        for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_p[i] = 0; e_x[i] = 0; e_t[i] = "R1"; end
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; curve_sel = '0;
        ap_en = 1'b0; ap_term = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        // R13: reset state
        n_checks++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            n_fail++;
            $display("FAIL R13: out_valid=%0b out_pix=%0d expected 0 0", out_valid, out_pix);
        end
        rst_n = 1'b1;
        flush();

        sweep(0, 0, 0, 0, "R4 R2 R3");
        sweep(2, 0, 0, 0, "R5");
        sweep(3, 0, 0, 0, "R6");
        sweep(1, 0, 0, 0, "R7 default");
        sweep(0, 0, 0, 1, "R1 gaps");

        // Custom programmable set; segment 5 overshoots 255.
        for (int j = 0; j < 6; j++) wr(j, 100 * (j + 1));
        wr(8, 0);  wr(9, 10); wr(10, 40); wr(11, 90);
        wr(12, 160); wr(13, 250); wr(14, 20);
        wr(16, 6); wr(17, 19); wr(18, 32); wr(19, 45);
        wr(20, 58); wr(21, 128); wr(22, 32);
        sweep(1, 0, 0, 0, "R7 R2 R3 R12");
        sweep(0, 0, 0, 0, "R8");
        sweep(2, 0, 0, 0, "R8");
        sweep(3, 0, 0, 0, "R8");

        // Aperture disabled: term must be ignored.
        sweep(0, 0, 200, 0, "R9");
        sweep(3, 0, -256, 0, "R9");

        // Before-curve aperture with clamping at both ends.
        wr(24, 0);
        sweep(3, 1, -256, 0, "R10");
        sweep(3, 1, -37, 0, "R10");
        sweep(0, 1, 100, 0, "R10");
        sweep(2, 1, 255, 0, "R10");

        // After-curve aperture with output clip.
        wr(24, 1);
        sweep(0, 1, -256, 0, "R11 R12");
        sweep(0, 1, -5, 0, "R11");
        sweep(3, 1, 60, 0, "R11 R12");
        sweep(2, 1, 255, 0, "R11 R12");
        sweep(1, 1, 30, 0, "R11 R12");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule